// File: doc/BRIEF.md
# CAN Fault Confinement and Bus-Off Recovery

This block holds the fault-confinement state of a single CAN node. It keeps a transmit error count and a receive error count, which it moves up and down on single-cycle event pulses from the protocol engine. From these counts it derives a warning flag, a passive flag and the bus-off state. When the transmit count would reach 256, the node goes bus-off. Both counts are then cleared. From that point the receive count is reused to measure bus idle time: it advances once for each run of 11 consecutive recessive bits, sampled on a bit-time strobe.

Two recovery policies are available. With automatic recovery enabled, the node returns to bus-on by itself once 128 idle runs have been counted. With automatic recovery disabled, a change-configuration request bit is raised on bus-off. The receive count then wraps at 128 and keeps counting, and the node stays off the bus until software writes 0 to the request bit. A sticky ready flag marks the first wrap, so software knows when the bus became quiet. A one-cycle bus-on pulse marks every return to bus-on, whichever policy caused it.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, both counts are 0, all status flags and the request bit are 0, the node is bus-on, and automatic recovery is disabled.
- R2: Outside bus-off, each transmit-error pulse adds 8 to the transmit count and each transmit-success pulse subtracts 1 from it. The count never goes below 0.
- R3: Outside bus-off, each receive-error pulse adds 1 to the receive count and each receive-success pulse subtracts 1 from it. The count never goes below 0.
- R4: The warning flag is 1 when either count is at least 96. The passive flag is 1 when either count is at least 128. Both flags take effect in the same cycle as the count change.
- R5: When a transmit-error pulse brings the transmit count to 256 or more, the node enters bus-off. Both counts become 0, and the warning and passive flags stay 1.
- R6: While bus-off, all four event pulses have no effect, and the transmit count reads 0.
- R7: While bus-off, the receive count increments once for every 11 consecutive strobed bits with bus_bit_i = 1 (recessive). A strobed bus_bit_i = 0 (dominant) restarts the run. Bits without a strobe are ignored.
- R8: With automatic recovery enabled, the request bit stays 0 on bus-off entry. When the receive count would reach 128, the node returns to bus-on, with both counts and both flags at 0.
- R9: With automatic recovery disabled, the request bit is 1 on bus-off entry. When the receive count would reach 128, it returns to 0 and keeps counting, the node stays bus-off, and the request bit stays 1.
- R10: In manual mode, the ready flag sets at the first wrap of the receive count. It stays set until the request bit is cleared.
- R11: A write with wr_req_i = 0 while the request bit is 1 returns the node to bus-on at any receive count, and clears the request bit, the ready flag, both counts and both flags. A write with wr_req_i = 1 has no effect.
- R12: bus_on_o is high for exactly one cycle after each bus-off to bus-on transition.
- R13: A write (wr_en_i = 1) loads wr_auto_i into the automatic-recovery enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_err_i | input | 1 | Transmit error event pulse |
| rx_err_i | input | 1 | Receive error event pulse |
| tx_ok_i | input | 1 | Successful transmission pulse |
| rx_ok_i | input | 1 | Successful reception pulse |
| bit_stb_i | input | 1 | Bit-time strobe |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| wr_en_i | input | 1 | Control write enable |
| wr_auto_i | input | 1 | Automatic-recovery enable value to write |
| wr_req_i | input | 1 | Request bit value to write (only 0 acts) |
| tec_o | output | 9 | Transmit error count |
| rec_o | output | 9 | Receive error count, or idle-run count while bus-off |
| warn_o | output | 1 | Warning flag |
| passive_o | output | 1 | Passive flag |
| busoff_o | output | 1 | Bus-off state |
| cfg_req_o | output | 1 | Change-configuration request bit |
| ready_o | output | 1 | Sticky flag: recovery-ready reached in manual mode |
| auto_o | output | 1 | Automatic-recovery enable |
| bus_on_o | output | 1 | One-cycle pulse on return to bus-on |

## Verification
The assertions check the following invariants on every cycle:
- The transmit count is 0 while bus-off.
- The receive count stays below 128 during bus-off.
- The request bit matches the mode on bus-off entry.
- The ready flag implies the request bit.
- The passive flag implies the warning flag.
- The idle run stays below 11.
- Each bus-on pulse is a single cycle that follows bus-off.

Only the bench scenarios can show the exact arithmetic and the exact cycles:
- the step sizes and flag thresholds;
- the cycle of bus-off entry;
- idle counting with interrupted runs and unstrobed bits;
- the manual wrap and sticky ready;
- early software recovery;
- automatic return after exactly 1408 recessive bits.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef struct packed {
    logic tx_err;
    logic rx_err;
    logic tx_ok;
    logic rx_ok;
  } fc_evt_t;
endpackage

// File: rtl/can_fc_err_arith.sv
module can_fc_err_arith #(
  parameter int W    = 9,
  parameter int STEP = 1
) (
  input  logic [W-1:0] cnt_i,
  input  logic         up_i,
  input  logic         down_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};
  localparam logic [W:0] INC  = (W+1)'(STEP);

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, cnt_i} + (up_i ? INC : '0);
    if (sum > MAXV) sum = MAXV;
    if (down_i && (sum != '0)) sum = sum - 1'b1;
    cnt_o = sum[W-1:0];
  end
endmodule

// File: rtl/can_fc_idle.sv
module can_fc_idle #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic strobe_i,
  input  logic recessive_i,
  output logic tick_o
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

  logic [RW-1:0] run_q, run_d;

  assign tick_o = en_i && strobe_i && recessive_i && (run_q == LAST);

  always_comb begin
    run_d = run_q;
    if (!en_i)                run_d = '0;
    else if (strobe_i) begin
      if (!recessive_i)       run_d = '0;
      else if (tick_o)        run_d = '0;
      else                    run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LAST);
  a_r7_dominant_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !recessive_i) |=> (run_q == '0));
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int CNT_W     = 9,
  parameter int WARN_LVL  = 96,
  parameter int PASS_LVL  = 128,
  parameter int BOFF_LVL  = 256,
  parameter int TX_STEP   = 8,
  parameter int IDLE_BITS = 11,
  parameter int RECOV_CNT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             bit_stb_i,
  input  logic             bus_bit_i,
  input  logic             wr_en_i,
  input  logic             wr_auto_i,
  input  logic             wr_req_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             warn_o,
  output logic             passive_o,
  output logic             busoff_o,
  output logic             cfg_req_o,
  output logic             ready_o,
  output logic             auto_o,
  output logic             bus_on_o
);
  import can_fc_pkg::*;

  localparam logic [CNT_W-1:0] WARN_V  = CNT_W'(WARN_LVL);
  localparam logic [CNT_W-1:0] PASS_V  = CNT_W'(PASS_LVL);
  localparam logic [CNT_W:0]   BOFF_V  = (CNT_W+1)'(BOFF_LVL);
  localparam logic [CNT_W-1:0] RECOV_V = CNT_W'(RECOV_CNT);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [CNT_W-1:0] tec_q, tec_d, rec_q, rec_d, tec_upd, rec_upd, rec_inc;
  logic busoff_q, busoff_d, req_q, req_d, ready_q, ready_d;
  logic auto_q, auto_d, warn_q, warn_d, pass_q, pass_d, buson_q, buson_d;
  logic tick, wrap, sw_clr, leave, enter;
  fc_evt_t evt;

  // events reach the counters only while bus-on
  always_comb begin
    evt.tx_err = tx_err_i && !busoff_q;
    evt.rx_err = rx_err_i && !busoff_q;
    evt.tx_ok  = tx_ok_i  && !busoff_q;
    evt.rx_ok  = rx_ok_i  && !busoff_q;
  end

  can_fc_err_arith #(.W(CNT_W), .STEP(TX_STEP)) u_tec_arith (
    .cnt_i(tec_q), .up_i(evt.tx_err), .down_i(evt.tx_ok), .cnt_o(tec_upd));

  can_fc_err_arith #(.W(CNT_W), .STEP(1)) u_rec_arith (
    .cnt_i(rec_q), .up_i(evt.rx_err), .down_i(evt.rx_ok), .cnt_o(rec_upd));

  can_fc_idle #(.RUN_LEN(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_sync_n), .en_i(busoff_q),
    .strobe_i(bit_stb_i), .recessive_i(bus_bit_i), .tick_o(tick));

  logic [CNT_W:0] tec_sum;
  always_comb begin
    tec_sum = {1'b0, tec_q} + (evt.tx_err ? (CNT_W+1)'(TX_STEP) : '0);
    rec_inc = rec_q + 1'b1;
    wrap    = busoff_q && tick && (rec_inc == RECOV_V);
    sw_clr  = busoff_q && req_q && wr_en_i && !wr_req_i;
    leave   = (wrap && auto_q) || sw_clr;
    enter   = !busoff_q && (tec_sum >= BOFF_V);
  end

  // next state
  always_comb begin
    tec_d    = tec_q;
    rec_d    = rec_q;
    busoff_d = busoff_q;
    req_d    = req_q;
    ready_d  = ready_q;
    warn_d   = warn_q;
    pass_d   = pass_q;
    buson_d  = 1'b0;
    auto_d   = wr_en_i ? wr_auto_i : auto_q;
    if (leave) begin
      tec_d    = '0;
      rec_d    = '0;
      busoff_d = 1'b0;
      req_d    = 1'b0;
      ready_d  = 1'b0;
      warn_d   = 1'b0;
      pass_d   = 1'b0;
      buson_d  = 1'b1;
    end else if (enter) begin
      tec_d    = '0;
      rec_d    = '0;
      busoff_d = 1'b1;
      req_d    = !auto_q;
      ready_d  = 1'b0;
      warn_d   = 1'b1;
      pass_d   = 1'b1;
    end else if (busoff_q) begin
      if (wrap) begin
        rec_d   = '0;
        ready_d = 1'b1;
        req_d   = 1'b1;
      end else if (tick) begin
        rec_d   = rec_inc;
      end
    end else begin
      tec_d  = tec_upd;
      rec_d  = rec_upd;
      warn_d = (tec_upd >= WARN_V) || (rec_upd >= WARN_V);
      pass_d = (tec_upd >= PASS_V) || (rec_upd >= PASS_V);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tec_q    <= '0;
      rec_q    <= '0;
      busoff_q <= 1'b0;
      req_q    <= 1'b0;
      ready_q  <= 1'b0;
      auto_q   <= 1'b0;
      warn_q   <= 1'b0;
      pass_q   <= 1'b0;
      buson_q  <= 1'b0;
    end else begin
      tec_q    <= tec_d;
      rec_q    <= rec_d;
      busoff_q <= busoff_d;
      req_q    <= req_d;
      ready_q  <= ready_d;
      auto_q   <= auto_d;
      warn_q   <= warn_d;
      pass_q   <= pass_d;
      buson_q  <= buson_d;
    end
  end

  assign tec_o     = tec_q;
  assign rec_o     = rec_q;
  assign warn_o    = warn_q;
  assign passive_o = pass_q;
  assign busoff_o  = busoff_q;
  assign cfg_req_o = req_q;
  assign ready_o   = ready_q;
  assign auto_o    = auto_q;
  assign bus_on_o  = buson_q;

  a_r6_busoff_tec_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busoff_q |-> (tec_q == '0));
  a_r9_rec_below_wrap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busoff_q |-> (rec_q < RECOV_V));
  a_r8_entry_req_mode: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busoff_q) |-> (req_q == !$past(auto_q)));
  a_r12_buson_follows_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    buson_q |-> (!busoff_q && $past(busoff_q)));
  a_r12_buson_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    buson_q |=> !buson_q);
  a_r10_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready_q |-> req_q);
  a_r11_req_only_busoff: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_q |-> busoff_q);
  a_r4_pass_implies_warn: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pass_q |-> warn_q);
endmodule

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, stb = 0, bbit = 1;
  logic we = 0, wauto = 0, wreq = 1;
  logic [8:0] tec, rec;
  logic warn, passive, busoff, req, ready, auto_en, bus_on;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_conf dut (
    .clk(clk), .rst_n(rst_n),
    .tx_err_i(tx_err), .rx_err_i(rx_err), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
    .bit_stb_i(stb), .bus_bit_i(bbit),
    .wr_en_i(we), .wr_auto_i(wauto), .wr_req_i(wreq),
    .tec_o(tec), .rec_o(rec), .warn_o(warn), .passive_o(passive),
    .busoff_o(busoff), .cfg_req_o(req), .ready_o(ready), .auto_o(auto_en),
    .bus_on_o(bus_on));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, return at the next negedge
  task automatic cyc(input logic te, input logic re, input logic to, input logic ro,
                     input logic s, input logic b, input logic w, input logic wa,
                     input logic wr);
    tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; stb = s; bbit = b;
    we = w; wauto = wa; wreq = wr;
    @(negedge clk);
    tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; stb = 0; bbit = 1;
    we = 0; wreq = 1;
  endtask

  task automatic rep(input int n, input logic te, input logic re, input logic to,
                     input logic ro, input logic s, input logic b);
    for (int i = 0; i < n; i++) cyc(te, re, to, ro, s, b, 0, 0, 1);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic go_busoff();
    rep(32, 1, 0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tec", tec, 0);
    chk("R1 rec", rec, 0);
    chk("R1 flags", {warn, passive, busoff, req, ready, bus_on}, 0);
    chk("R1 auto", auto_en, 0);
  endtask

  task automatic t_tx_count();
    do_reset();
    cyc(0, 0, 1, 0, 0, 1, 0, 0, 1);
    chk("R2 floor", tec, 0);
    rep(12, 1, 0, 0, 0, 0, 1);
    chk("R2 step8", tec, 96);
    chk("R4 warn tx", {warn, passive}, 2'b10);
    rep(4, 1, 0, 0, 0, 0, 1);
    chk("R4 passive tx", {warn, passive}, 2'b11);
    cyc(0, 0, 1, 0, 0, 1, 0, 0, 1);
    chk("R2 dec", tec, 127);
    chk("R4 passive drop", {warn, passive}, 2'b10);
  endtask

  task automatic t_rx_count();
    do_reset();
    cyc(0, 0, 0, 1, 0, 1, 0, 0, 1);
    chk("R3 floor", rec, 0);
    rep(96, 0, 1, 0, 0, 0, 1);
    chk("R3 inc", rec, 96);
    chk("R4 warn rx", {warn, passive}, 2'b10);
    cyc(0, 0, 0, 1, 0, 1, 0, 0, 1);
    chk("R3 dec", rec, 95);
    chk("R4 warn drop", warn, 0);
  endtask

  task automatic t_manual();
    do_reset();
    rep(31, 1, 0, 0, 0, 0, 1);
    chk("R5 before", {busoff, tec}, {1'b0, 9'd248});
    cyc(1, 0, 0, 0, 0, 1, 0, 0, 1);
    chk("R5 busoff", busoff, 1);
    chk("R5 counts", {tec, rec}, 0);
    chk("R5 flags held", {warn, passive}, 2'b11);
    chk("R9 req set", req, 1);
    cyc(1, 1, 1, 1, 0, 1, 0, 0, 1);
    chk("R6 ignored", {tec, rec}, 0);
    chk("R6 still off", busoff, 1);
    rep(10, 0, 0, 0, 0, 1, 1);
    rep(1, 0, 0, 0, 0, 1, 0);
    rep(10, 0, 0, 0, 0, 1, 1);
    chk("R7 dominant restart", rec, 0);
    rep(5, 0, 0, 0, 0, 0, 1);
    chk("R7 no strobe", rec, 0);
    rep(1, 0, 0, 0, 0, 1, 1);
    chk("R7 one run", rec, 1);
    rep(127*11 - 1, 0, 0, 0, 0, 1, 1);
    chk("R7 count 127", rec, 127);
    chk("R10 not yet", ready, 0);
    rep(1, 0, 0, 0, 0, 1, 1);
    chk("R9 wrap", rec, 0);
    chk("R9 stay off", {busoff, req}, 2'b11);
    chk("R10 ready", ready, 1);
    chk("R12 no pulse", bus_on, 0);
    rep(11, 0, 0, 0, 0, 1, 1);
    chk("R9 keeps counting", rec, 1);
    chk("R10 sticky", ready, 1);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 1);
    chk("R11 write1 no effect", {busoff, req, ready}, 3'b111);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R11 bus on", {busoff, req, ready}, 0);
    chk("R11 cleared", {tec, rec, 7'(warn), 7'(passive)}, 0);
    chk("R12 pulse", bus_on, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 1);
    chk("R12 single", bus_on, 0);
  endtask

  task automatic t_early_clear();
    do_reset();
    go_busoff();
    rep(33, 0, 0, 0, 0, 1, 1);
    chk("R7 three runs", rec, 3);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R11 early", {busoff, req, bus_on}, 3'b001);
    chk("R11 rec zero", rec, 0);
  endtask

  task automatic t_auto();
    do_reset();
    cyc(0, 0, 0, 0, 0, 1, 1, 1, 1);
    chk("R13 auto set", auto_en, 1);
    go_busoff();
    chk("R8 off no req", {busoff, req}, 2'b10);
    rep(128*11 - 1, 0, 0, 0, 0, 1, 1);
    chk("R8 still off", {busoff, rec}, {1'b1, 9'd127});
    rep(1, 0, 0, 0, 0, 1, 1);
    chk("R8 auto back", busoff, 0);
    chk("R8 cleared", {tec, rec, 7'(warn), 7'(passive)}, 0);
    chk("R12 auto pulse", bus_on, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 1);
    chk("R12 auto single", bus_on, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 1);
    chk("R13 auto clr", auto_en, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_tx_count();
    t_rx_count();
    t_manual();
    t_early_clear();
    t_auto();
    finish_run();
  end
endmodule